// File: doc/BRIEF.md
# Serial SRAM SPI Slave Front End

This block sits between an SPI bus and a byte-wide synchronous memory port. It takes a command byte, an address sent high byte first and a stream of data bytes, and it turns them into read and write accesses at an address that advances by one per byte. It also holds a small status register with a write-enable latch and two block-protect bits. The bus pins are sampled by the system clock `clk`. SCK high and low phases must each last at least 6 `clk` cycles, so that a prefetched read byte is ready before the next falling SCK edge.

The memory side is a stream with valid strobes only. `mem_re` and `mem_we` each pulse for one cycle per byte. There is no ready signal and no back-pressure, because the SPI master owns the bit clock and cannot be stalled. The memory must accept every strobe in the cycle it is given and return read data on `mem_rdata` exactly one cycle after `mem_re`. The serial output is given as a data bit and an enable, and the pad turns these into a tri-state driver.

Top module: `spi_sram_slave`

## Requirements
- R1: SI is taken on rising SCK edges, and `so_data` changes only after falling SCK edges. SCK idling low (mode 0) and SCK idling high (mode 3) both work.
- R2: Bytes move most significant bit first in both directions.
- R3: Command 0x03 followed by a two-byte address (high byte first) streams memory bytes out. The first byte comes from that address, and each later byte comes from the next address.
- R4: Command 0x02 followed by an address issues one `mem_we` strobe per data byte, at addresses that go up by one. For reads and writes alike, the address wraps from 0xFFFF to 0x0000.
- R5: While `cs_n` is high, SCK and SI have no effect and `so_oe` stays low. After reset, `so_oe`, `mem_we` and `mem_re` are low.
- R6: After reset, no command takes effect until a falling edge of `cs_n` has been seen.
- R7: An unknown command byte leaves `so_oe` low and makes every later bit of that selection have no effect.
- R8: While `hold_n` is low during a selection, SCK edges are ignored and `so_oe` is low. The bit position is kept, and the transfer resumes when `hold_n` returns high.
- R9: Command 0x05 returns the status byte, repeated for as many bytes as are clocked. Its layout is bits 7:4 zero, bit 3 BP1, bit 2 BP0, bit 1 the write-enable latch, bit 0 zero. Command 0x01 loads BP1:BP0 from data bits 3:2, and only when the latch is set.
- R10: Command 0x06 sets the write-enable latch and command 0x04 clears it. Memory writes need the latch set. The latch clears when `cs_n` rises after a 0x02 or 0x01 command.
- R11: The protect code BP1:BP0 selects the protected range: 00 none, 01 addresses with bits 15:14 = 11, 10 addresses with bit 15 = 1, 11 all addresses. A byte aimed at a protected address gives no strobe, but the address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial bit clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the master |
| hold_n | input | 1 | Active-low pause |
| so_data | output | 1 | Serial data bit to the master |
| so_oe | output | 1 | Drive enable for the serial output pad |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe (valid, one cycle per byte) |
| mem_re | output | 1 | Read strobe (valid, one cycle per byte) |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |

## Verification
The bench builds the block with the default ADDR_W of 16. With that width the 0xFFFF to 0x0000 wrap can be reached with two-byte bursts, and so can the protection edges at 0x7FFF/0x8000 and 0xBFFF/0xC000, each written with one byte on each side. The same width lets a sparse bench memory with a computed default pattern check reads from any address without storing the whole array.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_SRWR, PH_SRRD, PH_DONE, PH_LOCK
  } phase_e;

  // Block-protect decode from the two top address bits.
  function automatic logic is_protected(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   is_protected = 1'b0;
      2'b01:   is_protected = (top2 == 2'b11);
      2'b10:   is_protected = top2[1];
      default: is_protected = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic sel,
  output logic hold_ok,
  output logic si_s
);
  logic sck_q, sck_d, cs_q, cs_d, si_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
      cs_q   <= 1'b0;
      cs_d   <= 1'b0;
      si_q   <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      sck_q  <= sck;
      sck_d  <= sck_q;
      cs_q   <= cs_n;
      cs_d   <= cs_q;
      si_q   <= si;
      hold_q <= hold_n;
    end
  end

  logic active;
  assign active   = ~cs_q & hold_q;
  assign sck_rise = active & sck_q & ~sck_d;
  assign sck_fall = active & ~sck_q & sck_d;
  assign cs_fall  = cs_d & ~cs_q;
  assign sel      = ~cs_q;
  assign hold_ok  = hold_q;
  assign si_s     = si_q;
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_done
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      byte_q    <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (shift_en) begin
        byte_q    <= {byte_q[BYTE_W-2:0], din};
        cnt       <= (cnt == LAST) ? '0 : cnt + 1'b1;
        byte_done <= (cnt == LAST);
      end
    end
  end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift,
  input  logic              drive,
  output logic              so_data,
  output logic              so_oe
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      so_data <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      so_oe <= drive;
      if (load) begin
        sh <= load_val;
      end else if (shift) begin
        so_data <= sh[BYTE_W-1];
        sh      <= {sh[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so_data,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
  localparam int ASH_W      = ADDR_BYTES * BYTE_W;
  localparam int AB_W       = $clog2(ADDR_BYTES);
  localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

  logic sck_rise, sck_fall, cs_fall, sel, hold_s, si_s;
  logic armed;
  logic [BYTE_W-1:0] rx_byte;
  logic byte_done;

  spi_pin_sampler u_pins (
    .clk, .rst_n, .sck, .cs_n, .si, .hold_n,
    .sck_rise, .sck_fall, .cs_fall, .sel, .hold_ok(hold_s), .si_s
  );

  spi_rx_shifter #(.BYTE_W(BYTE_W)) u_rx (
    .clk, .rst_n,
    .clear(~sel), .shift_en(sck_rise & armed), .din(si_s),
    .byte_q(rx_byte), .byte_done
  );

  phase_e state;
  logic is_rd, wcmd, wel, re_d;
  logic [1:0] bp;
  logic [ASH_W-BYTE_W-1:0] addr_sh;
  logic [AB_W-1:0] abyte;
  logic [ADDR_W-1:0] cur_addr;
  logic [ASH_W-1:0] addr_full;
  logic [ADDR_W-1:0] addr_new;
  logic [BYTE_W-1:0] status_byte;

  assign addr_full   = {addr_sh, rx_byte};
  assign addr_new    = addr_full[ADDR_W-1:0];
  assign status_byte = {{(BYTE_W-4){1'b0}}, bp, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_CMD;
      armed     <= 1'b0;
      is_rd     <= 1'b0;
      wcmd      <= 1'b0;
      wel       <= 1'b0;
      bp        <= 2'b00;
      addr_sh   <= '0;
      abyte     <= '0;
      cur_addr  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      re_d      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      re_d   <= mem_re;
      if (cs_fall) armed <= 1'b1;
      if (!sel) begin
        state <= PH_CMD;
        if (wcmd) wel <= 1'b0;
        wcmd  <= 1'b0;
      end else if (byte_done) begin
        unique case (state)
          PH_CMD: begin
            abyte <= '0;
            case (rx_byte)
              CMD_WREN:  begin wel <= 1'b1; state <= PH_DONE; end
              CMD_WRDI:  begin wel <= 1'b0; state <= PH_DONE; end
              CMD_RDSR:  state <= PH_SRRD;
              CMD_WRSR:  begin wcmd <= 1'b1; state <= PH_SRWR; end
              CMD_READ:  begin is_rd <= 1'b1; state <= PH_ADDR; end
              CMD_WRITE: begin is_rd <= 1'b0; wcmd <= 1'b1; state <= PH_ADDR; end
              default:   state <= PH_LOCK;
            endcase
          end
          PH_ADDR: begin
            addr_sh <= addr_full[ASH_W-BYTE_W-1:0];
            abyte   <= abyte + 1'b1;
            if (abyte == AB_LAST) begin
              if (is_rd) begin
                mem_addr <= addr_new;
                mem_re   <= 1'b1;
                cur_addr <= addr_new + 1'b1;
                state    <= PH_RDATA;
              end else begin
                cur_addr <= addr_new;
                state    <= PH_WDATA;
              end
            end
          end
          PH_WDATA: begin
            mem_addr  <= cur_addr;
            mem_wdata <= rx_byte;
            mem_we    <= wel && !is_protected(bp, cur_addr[ADDR_W-1:ADDR_W-2]);
            cur_addr  <= cur_addr + 1'b1;
          end
          PH_RDATA: begin
            mem_addr <= cur_addr;
            mem_re   <= 1'b1;
            cur_addr <= cur_addr + 1'b1;
          end
          PH_SRWR: begin
            if (wel) bp <= rx_byte[3:2];
            state <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  logic reading, tx_load;
  logic [BYTE_W-1:0] tx_val;
  assign reading = (state == PH_RDATA) || (state == PH_SRRD);

  always_comb begin
    tx_load = re_d;
    tx_val  = mem_rdata;
    if (!re_d && sel && byte_done &&
        ((state == PH_CMD && rx_byte == CMD_RDSR) || state == PH_SRRD)) begin
      tx_load = 1'b1;
      tx_val  = status_byte;
    end
  end

  spi_tx_shifter #(.BYTE_W(BYTE_W)) u_tx (
    .clk, .rst_n,
    .load(tx_load), .load_val(tx_val),
    .shift(sck_fall & reading),
    .drive(sel & hold_s & reading),
    .so_data, .so_oe
  );

  p_so_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_data) |-> $past(sck_fall));
  p_desel_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe);
  p_unarmed_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!mem_we && !mem_re));
  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOCK) |=> (!so_oe && !mem_we && !mem_re));
  p_hold_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> !so_oe);
  p_bp_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(bp));
  p_write_needs_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wel));
  p_no_protected_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !is_protected(bp, mem_addr[ADDR_W-1:ADDR_W-2]));
endmodule

// File: tb/test_spi_sram_slave.sv
module test_spi_sram_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so_data, so_oe, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sram_slave i_spi_sram_slave (
    .clk, .rst_n, .sck, .cs_n, .si, .hold_n, .so_data, .so_oe,
    .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata
  );

  typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_t;
  wr_t exp_wr[$];
  logic [7:0] exp_rd[$];
  logic [7:0] txq[$], rxq[$];
  logic [7:0] bmem [int];
  logic [7:0] rmem [int];
  int n_chk = 0, n_fail = 0, strobes = 0;
  bit mode3 = 0, oe_seen, r1_bad = 0, hold_bad;
  bit wel_m = 0;
  logic [1:0] bp_m = 2'b00;

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return rmem.exists(int'(a)) ? rmem[int'(a)] : dflt(a);
  endfunction

  function automatic bit prot_m(input logic [15:0] a);
    case (bp_m)
      2'b00: return 1'b0;
      2'b01: return a[15:14] == 2'b11;
      2'b10: return a[15];
      default: return 1'b1;
    endcase
  endfunction

  // bench memory array model
  always @(posedge clk) begin
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : dflt(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) strobes++;
    if (rst_n && mem_we) begin
      if (exp_wr.size() == 0) chk(1'b0, "R10/R11 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        wr_t w;
        w = exp_wr.pop_front();
        chk(mem_addr == w.a && mem_wdata == w.d, "R4 write", {mem_addr, mem_wdata}, {w.a, w.d});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b, input bit do_hold, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic s0;
      sck = 1'b0; si = b[i];
      wait_clk(HALF);
      if (do_hold && i == 4) begin
        hold_n = 1'b0;
        wait_clk(3);
        if (so_oe) hold_bad = 1;
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; si = ~si; wait_clk(HALF);
          sck = 1'b0; wait_clk(HALF);
          if (so_oe) hold_bad = 1;
        end
        si = b[i];
        hold_n = 1'b1;
        wait_clk(HALF);
      end
      r[i] = so_data;
      if (so_oe) oe_seen = 1;
      sck = 1'b1;
      wait_clk(2);
      s0 = so_data;
      wait_clk(HALF - 2);
      if (so_data !== s0) r1_bad = 1;
    end
  endtask

  task automatic run_txn(input bit hold_last);
    logic [7:0] r;
    rxq = {};
    oe_seen = 0;
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < txq.size(); k++) begin
      spi_byte(txq[k], hold_last && (k == txq.size() - 1), r);
      rxq.push_back(r);
    end
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    txq = {op};
    run_txn(0);
    if (op == 8'h06) wel_m = 1;
    if (op == 8'h04) wel_m = 0;
  endtask

  task automatic rdsr(input string req);
    logic [7:0] e;
    e = {4'b0, bp_m, wel_m, 1'b0};
    txq = {8'h05, 8'h00, 8'h00};
    run_txn(0);
    chk(rxq[1] == e, req, rxq[1], e);
    chk(rxq[2] == e, "R9 status repeat", rxq[2], e);
  endtask

  task automatic wrsr(input logic [7:0] v);
    txq = {8'h01, v};
    run_txn(0);
    if (wel_m) bp_m = v[3:2];
    wel_m = 0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d[$]);
    txq = {8'h02, a[15:8], a[7:0]};
    for (int k = 0; k < d.size(); k++) begin
      logic [15:0] ak;
      ak = a + 16'(k);
      txq.push_back(d[k]);
      if (wel_m && !prot_m(ak)) begin
        exp_wr.push_back('{a: ak, d: d[k]});
        rmem[int'(ak)] = d[k];
      end
    end
    run_txn(0);
    wel_m = 0;
    chk(exp_wr.size() == 0, "R4 pending writes", exp_wr.size(), 0);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input bit hold_last, input string req);
    txq = {8'h03, a[15:8], a[7:0]};
    for (int k = 0; k < n; k++) begin
      txq.push_back(8'h00);
      exp_rd.push_back(ref_rd(a + 16'(k)));
    end
    run_txn(hold_last);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      chk(rxq[3+k] == e, req, rxq[3+k], e);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    int s0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk(!so_oe && !mem_we && !mem_re, "R5 reset outputs", {so_oe, mem_we, mem_re}, 0);

    // R6: selected through reset with no falling edge: commands ignored
    oe_seen = 0;
    spi_byte(8'h06, 0, r);
    spi_byte(8'h05, 0, r);
    spi_byte(8'h00, 0, r);
    chk(!oe_seen, "R6 no output before first select edge", oe_seen, 0);
    sck = 1'b0; wait_clk(HALF);
    cs_n = 1'b1; wait_clk(2 * HALF);
    rdsr("R6 latch untouched before first select edge");

    cmd1(8'h06);
    rdsr("R10 WREN sets latch");
    cmd1(8'h04);
    rdsr("R10 WRDI clears latch");

    cmd1(8'h06);
    do_write(16'h1234, {8'hA5, 8'h3C, 8'h81});
    rdsr("R10 latch cleared after write");
    do_read(16'h1234, 4, 0, "R3 burst read");
    chk(rxq[5] == 8'h81, "R2 msb first", rxq[5], 8'h81);

    do_write(16'h2000, {8'h11});
    do_read(16'h2000, 1, 0, "R10 write without latch dropped");

    cmd1(8'h06);
    do_write(16'hFFFF, {8'hC3, 8'h7E});
    do_read(16'hFFFE, 4, 0, "R4 address wrap");

    cmd1(8'h06); wrsr(8'h04);
    rdsr("R9 status after BP=01");
    cmd1(8'h06);
    do_write(16'hBFFF, {8'h12, 8'h34});
    do_read(16'hBFFF, 2, 0, "R11 quarter protect");

    cmd1(8'h06); wrsr(8'h08);
    rdsr("R9 status after BP=10");
    cmd1(8'h06);
    do_write(16'h7FFF, {8'h56, 8'h78});
    do_read(16'h7FFF, 2, 0, "R11 half protect");

    cmd1(8'h06); wrsr(8'h0C);
    cmd1(8'h06);
    do_write(16'h0010, {8'h9A});
    do_read(16'h0010, 1, 0, "R11 full protect");
    wrsr(8'h00);
    rdsr("R9 WRSR without latch ignored");
    cmd1(8'h06); wrsr(8'h00);
    rdsr("R9 BP cleared");

    // R7: invalid command locks the selection
    txq = {8'hFF, 8'h06, 8'h03, 8'h00};
    run_txn(0);
    chk(!oe_seen, "R7 output stays off after bad command", oe_seen, 0);
    rdsr("R7 bits after bad command ignored");
    cmd1(8'h06);
    s0 = strobes;
    txq = {8'hAB, 8'h02, 8'h00, 8'h10, 8'hEE};
    run_txn(0);
    chk(strobes == s0, "R7 no memory access after bad command", strobes - s0, 0);
    rdsr("R7 latch kept");
    cmd1(8'h04);

    // R8: hold in the middle of a read byte
    hold_bad = 0;
    do_read(16'h1234, 2, 1, "R8 read across hold");
    chk(!hold_bad, "R8 output off during hold", hold_bad, 0);

    // R5: traffic while deselected
    s0 = strobes;
    oe_seen = 0;
    for (int i = 0; i < 16; i++) begin
      si = i[0]; sck = 1'b1; wait_clk(HALF);
      if (so_oe) oe_seen = 1;
      sck = 1'b0; wait_clk(HALF);
    end
    chk(!oe_seen && strobes == s0, "R5 deselected traffic ignored", {oe_seen, 16'(strobes - s0)}, 0);
    rdsr("R5 state unchanged while deselected");

    // R1: mode 3
    mode3 = 1;
    do_read(16'h1234, 3, 0, "R1 mode 3 read");
    rdsr("R1 mode 3 status");
    mode3 = 0;
    chk(!r1_bad, "R1 output stable while SCK high", r1_bad, 0);

    finish_up();
  end
endmodule